// File: doc/BRIEF.md
# Multi-Line Write-Combining Buffer

This block gathers small uncached stores into line-sized entries before they reach the memory bus. It keeps four entries, each holding a 64-byte line address, the line's data and one valid bit per byte. A store of up to 8 bytes carries a byte address, data and byte enables. A store to a line that already has an entry merges into that entry. A store to a new line takes the lowest free entry. If every entry is in use, the lowest-index entry is written out to the bus first, and the new line then takes its place.

Entries leave the block in any order: no write ordering is kept between lines. A fully written line goes out as one full-line burst. A line with gaps goes out as a partial write that carries its byte mask. Four sideband event inputs force every occupied entry onto the bus: interrupt, I/O operation, uncacheable access, and fence/flush. A programmable idle counter does the same when no store has arrived for a set number of cycles, so data cannot sit in the buffer forever. A completion pulse marks the end of each forced drain. A store that would cross a line boundary is refused and flagged.

Top module: `wc_line_buffer`

## Requirements
- R1: After reset no entry is occupied: `bus_valid`, `flush_done` and `st_err` are 0 and `st_ready` is 1.
- R2: A store at byte address A with line offset o = A[5:0] writes byte k of `st_data` (bits 8k+7..8k) to line byte o+k for every k with `st_be[k]` set. It sets `bus_mask` bit o+k, and only those bits. On the bus, line byte j is `bus_data[8j+7:8j]`.
- R3: A later store to a line already held merges into the same entry. It overwrites the bytes it carries, and the mask becomes the union of both masks.
- R4: Stores to two different lines occupy two entries. Interleaved stores to those lines keep merging into their own entries, and each line comes out once with its own data.
- R5: An entry whose 64 mask bits are all set is presented with `bus_full` = 1.
- R6: An entry with any mask bit clear is presented with `bus_full` = 0 and its byte mask. Bytes that were never written read as zero.
- R7: A one-cycle pulse on any of `irq_evt`, `io_evt`, `uc_evt` or `fence_evt` starts a drain of every occupied entry, lowest entry index first. `bus_valid` is high in the cycle after the pulse.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_addr`, `bus_mask` and `bus_data` hold their values and `st_ready` is 0.
- R9: With `idle_limit` = L ≠ 0, if no store is accepted for L cycles while any entry is occupied, a full drain starts: `bus_valid` rises L cycles after the clock edge that accepted the last store. L = 0 disables the timer.
- R10: If all four entries are occupied and a store to a fifth line is accepted, entry 0 is offered to the bus in the next cycle with `st_ready` low. Once it is taken, the new line lives in entry 0. A later drain therefore sends the newest line before older lines.
- R11: `flush_done` pulses for one cycle in the cycle after the bus accepts the last entry of a drain. If a drain event arrives while no entry is occupied, the pulse comes in the cycle after the event.
- R12: A store whose enabled bytes would reach past line byte 63 is refused: `st_err` pulses in the next cycle and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | 32 | Byte address of the store |
| st_data | input | 64 | Store data, byte k in bits 8k+7..8k |
| st_be | input | 8 | Byte enables for the store data |
| st_err | output | 1 | One-cycle pulse: last accepted store crossed a line |
| irq_evt | input | 1 | Interrupt drain event |
| io_evt | input | 1 | I/O operation drain event |
| uc_evt | input | 1 | Uncacheable access drain event |
| fence_evt | input | 1 | Fence or flush drain event |
| idle_limit | input | 16 | Idle cycles before an automatic drain, 0 = off |
| bus_valid | output | 1 | A line is offered to the bus |
| bus_ready | input | 1 | Bus takes the offered line |
| bus_addr | output | 32 | Line-aligned address of the offered line |
| bus_data | output | 512 | Line data, byte j in bits 8j+7..8j |
| bus_mask | output | 64 | Written-byte mask of the offered line |
| bus_full | output | 1 | Offered line is completely written |
| flush_done | output | 1 | One-cycle pulse at the end of a drain |

## Verification
Every result comes from registered state, and inputs are driven on falling edges. A store accepted at a rising edge is therefore visible at the next falling edge: as a refusal flag, as a victim on the bus, or as merged state that shows up later on the bus. A drain event pulse puts the first line on the bus one cycle after the pulse. The completion pulse appears one cycle after the edge on which the bus takes the last line. The idle drain appears exactly L edges after the accepting edge, so the bench checks that the bus is still quiet one cycle before that point and active at it. Buffer contents are never read directly: each scenario drives the bus side and compares address, mask, full flag and data against byte maps built in the bench from the stores it sent.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
    localparam int ADDR_W      = 32;
    localparam int LINE_BYTES  = 64;
    localparam int STORE_BYTES = 8;
    localparam int OFF_W       = $clog2(LINE_BYTES);
    localparam int TAG_W       = ADDR_W - OFF_W;
    localparam int LINE_BITS   = LINE_BYTES * 8;
    localparam int STORE_BITS  = STORE_BYTES * 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_EVICT = 2'd2
    } wcb_state_e;

    typedef struct packed {
        logic                  live;
        logic [TAG_W-1:0]      tag;
        logic [LINE_BYTES-1:0] mask;
        logic [LINE_BITS-1:0]  data;
    } wcb_line_t;
endpackage

// File: rtl/wcb_lane_place.sv
module wcb_lane_place
    import wcb_pkg::*;
(
    input  logic [OFF_W-1:0]       offset,
    input  logic [STORE_BITS-1:0]  store_data,
    input  logic [STORE_BYTES-1:0] store_be,
    output logic [LINE_BYTES-1:0]  line_mask,
    output logic [LINE_BITS-1:0]   line_data,
    output logic                   spills
);
    localparam int WIDE_BYTES = LINE_BYTES + STORE_BYTES;

    logic [WIDE_BYTES-1:0] wide_mask;
    logic [STORE_BITS-1:0] gated_data;

    // Zero the lanes whose enables are clear before shifting into place.
    always_comb begin
        for (int k = 0; k < STORE_BYTES; k++) begin
            gated_data[k*8 +: 8] = store_be[k] ? store_data[k*8 +: 8] : 8'h00;
        end
    end

    always_comb begin
        wide_mask = {{LINE_BYTES{1'b0}}, store_be} << offset;
        line_mask = wide_mask[LINE_BYTES-1:0];
        spills    = |wide_mask[WIDE_BYTES-1:LINE_BYTES];
        line_data = {{(LINE_BITS-STORE_BITS){1'b0}}, gated_data} << {offset, 3'b000};
    end
endmodule

// File: rtl/wcb_merge.sv
module wcb_merge
    import wcb_pkg::*;
(
    input  logic [LINE_BYTES-1:0] old_mask,
    input  logic [LINE_BITS-1:0]  old_data,
    input  logic [LINE_BYTES-1:0] new_mask,
    input  logic [LINE_BITS-1:0]  new_data,
    output logic [LINE_BYTES-1:0] out_mask,
    output logic [LINE_BITS-1:0]  out_data
);
    assign out_mask = old_mask | new_mask;

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        assign out_data[b*8 +: 8] = new_mask[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
    end
endmodule

// File: rtl/wcb_pick_lowest.sv
module wcb_pick_lowest #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/wcb_idle_timer.sv
module wcb_idle_timer #(
    parameter int TIMER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic               kick,
    input  logic [TIMER_W-1:0] limit,
    output logic               expire
);
    logic [TIMER_W-1:0] count_d, count_q;

    always_comb begin
        if (!arm || kick) begin
            count_d = '0;
        end else begin
            count_d = count_q + 1'b1;
        end
        expire = arm && !kick && (limit != '0) && (count_q == limit - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end
endmodule

// File: rtl/wc_line_buffer.sv
module wc_line_buffer
    import wcb_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int TIMER_W     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    output logic                   st_ready,
    input  logic [ADDR_W-1:0]      st_addr,
    input  logic [STORE_BITS-1:0]  st_data,
    input  logic [STORE_BYTES-1:0] st_be,
    output logic                   st_err,
    input  logic                   irq_evt,
    input  logic                   io_evt,
    input  logic                   uc_evt,
    input  logic                   fence_evt,
    input  logic [TIMER_W-1:0]     idle_limit,
    output logic                   bus_valid,
    input  logic                   bus_ready,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [LINE_BITS-1:0]   bus_data,
    output logic [LINE_BYTES-1:0]  bus_mask,
    output logic                   bus_full,
    output logic                   flush_done
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    typedef struct packed {
        wcb_state_e                       state;
        wcb_line_t [NUM_ENTRIES-1:0]      lines;
        logic [TAG_W-1:0]                 held_tag;
        logic [LINE_BYTES-1:0]            held_mask;
        logic [LINE_BITS-1:0]             held_data;
        logic                             flush_pend;
        logic                             done;
        logic                             err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [TAG_W-1:0]       st_tag;
    logic [LINE_BYTES-1:0]  place_mask;
    logic [LINE_BITS-1:0]   place_data;
    logic                   place_spills;
    logic [NUM_ENTRIES-1:0] live_vec;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]       hit_idx, free_idx, live_idx;
    logic                   hit_any, free_any, live_any;
    logic [LINE_BYTES-1:0]  merged_mask;
    logic [LINE_BITS-1:0]   merged_data;
    logic                   accept;
    logic                   timer_expire;
    logic                   drain_evt;
    logic                   live_after;
    logic                   last_live;

    assign st_tag = st_addr[ADDR_W-1:OFF_W];

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
        assign live_vec[i] = regs_q.lines[i].live;
        assign hit_vec[i]  = regs_q.lines[i].live && (regs_q.lines[i].tag == st_tag);
    end

    wcb_lane_place u_place (
        .offset     (st_addr[OFF_W-1:0]),
        .store_data (st_data),
        .store_be   (st_be),
        .line_mask  (place_mask),
        .line_data  (place_data),
        .spills     (place_spills)
    );

    wcb_pick_lowest #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_hit (
        .req (hit_vec), .idx (hit_idx), .found (hit_any)
    );

    wcb_pick_lowest #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_free (
        .req (~live_vec), .idx (free_idx), .found (free_any)
    );

    wcb_pick_lowest #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_pick_live (
        .req (live_vec), .idx (live_idx), .found (live_any)
    );

    wcb_merge u_merge (
        .old_mask (regs_q.lines[hit_idx].mask),
        .old_data (regs_q.lines[hit_idx].data),
        .new_mask (place_mask),
        .new_data (place_data),
        .out_mask (merged_mask),
        .out_data (merged_data)
    );

    wcb_idle_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    ((regs_q.state == ST_IDLE) && live_any),
        .kick   (accept),
        .limit  (idle_limit),
        .expire (timer_expire)
    );

    assign st_ready  = (regs_q.state == ST_IDLE);
    assign accept    = st_valid && st_ready;
    assign drain_evt = irq_evt || io_evt || uc_evt || fence_evt || timer_expire;
    assign last_live = ((live_vec & ~(NUM_ENTRIES'(1) << live_idx)) == '0);

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        regs_d.err  = 1'b0;
        live_after  = 1'b0;

        unique case (regs_q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (place_spills) begin
                        regs_d.err = 1'b1;
                    end else if (hit_any) begin
                        regs_d.lines[hit_idx].mask = merged_mask;
                        regs_d.lines[hit_idx].data = merged_data;
                    end else if (free_any) begin
                        regs_d.lines[free_idx].live = 1'b1;
                        regs_d.lines[free_idx].tag  = st_tag;
                        regs_d.lines[free_idx].mask = place_mask;
                        regs_d.lines[free_idx].data = place_data;
                    end else begin
                        regs_d.held_tag  = st_tag;
                        regs_d.held_mask = place_mask;
                        regs_d.held_data = place_data;
                        regs_d.state     = ST_EVICT;
                    end
                end
                for (int i = 0; i < NUM_ENTRIES; i++) begin
                    live_after = live_after | regs_d.lines[i].live;
                end
                if (drain_evt) begin
                    if (regs_d.state == ST_EVICT) begin
                        regs_d.flush_pend = 1'b1;
                    end else if (live_after) begin
                        regs_d.state = ST_DRAIN;
                    end else begin
                        regs_d.done = 1'b1;
                    end
                end
            end

            ST_DRAIN: begin
                if (!live_any) begin
                    regs_d.state = ST_IDLE;
                    regs_d.done  = 1'b1;
                end else if (bus_ready) begin
                    regs_d.lines[live_idx].live = 1'b0;
                    if (last_live) begin
                        regs_d.state = ST_IDLE;
                        regs_d.done  = 1'b1;
                    end
                end
            end

            ST_EVICT: begin
                if (bus_ready) begin
                    regs_d.lines[live_idx].live = 1'b1;
                    regs_d.lines[live_idx].tag  = regs_q.held_tag;
                    regs_d.lines[live_idx].mask = regs_q.held_mask;
                    regs_d.lines[live_idx].data = regs_q.held_data;
                    regs_d.flush_pend           = 1'b0;
                    regs_d.state = (regs_q.flush_pend || drain_evt) ? ST_DRAIN : ST_IDLE;
                end else if (drain_evt) begin
                    regs_d.flush_pend = 1'b1;
                end
            end

            default: begin
                regs_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign bus_valid  = (regs_q.state != ST_IDLE) && live_any;
    assign bus_addr   = {regs_q.lines[live_idx].tag, {OFF_W{1'b0}}};
    assign bus_data   = regs_q.lines[live_idx].data;
    assign bus_mask   = regs_q.lines[live_idx].mask;
    assign bus_full   = &regs_q.lines[live_idx].mask;
    assign flush_done = regs_q.done;
    assign st_err     = regs_q.err;
endmodule

// File: rtl/wcb_checker.sv
module wcb_checker
    import wcb_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  st_valid,
    input logic                  st_ready,
    input logic                  st_err,
    input logic                  bus_valid,
    input logic                  bus_ready,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic [LINE_BITS-1:0]  bus_data,
    input logic [LINE_BYTES-1:0] bus_mask,
    input logic                  flush_done
);
    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_mask) && $stable(bus_data));

    assert_no_store_on_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !st_ready);

    assert_nonempty_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_mask != '0));

    assert_err_follows_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> $past(st_valid && st_ready));

    assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> !bus_valid && st_ready);
endmodule

bind wc_line_buffer wcb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_err     (st_err),
    .bus_valid  (bus_valid),
    .bus_ready  (bus_ready),
    .bus_addr   (bus_addr),
    .bus_data   (bus_data),
    .bus_mask   (bus_mask),
    .flush_done (flush_done)
);

// File: tb/wc_line_buffer_tb.sv
module wc_line_buffer_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [31:0]  st_addr = '0;
    logic [63:0]  st_data = '0;
    logic [7:0]   st_be = '0;
    logic         st_err;
    logic         irq_evt = 1'b0, io_evt = 1'b0, uc_evt = 1'b0, fence_evt = 1'b0;
    logic [15:0]  idle_limit = '0;
    logic         bus_valid;
    logic         bus_ready = 1'b0;
    logic [31:0]  bus_addr;
    logic [511:0] bus_data;
    logic [63:0]  bus_mask;
    logic         bus_full;
    logic         flush_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wc_line_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
        .st_data(st_data), .st_be(st_be), .st_err(st_err),
        .irq_evt(irq_evt), .io_evt(io_evt), .uc_evt(uc_evt), .fence_evt(fence_evt),
        .idle_limit(idle_limit),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_mask(bus_mask), .bus_full(bus_full),
        .flush_done(flush_done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_wide(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_store(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        while (!st_ready) @(negedge clk);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: irq_evt = 1'b1;
            1: io_evt = 1'b1;
            2: uc_evt = 1'b1;
            default: fence_evt = 1'b1;
        endcase
        @(negedge clk);
        irq_evt = 1'b0; io_evt = 1'b0; uc_evt = 1'b0; fence_evt = 1'b0;
    endtask

    task automatic take_line(input string req, input logic [31:0] ea, input logic [63:0] em,
                             input bit ef, input logic [511:0] ed, input bit last);
        for (int n = 0; n < 20 && !bus_valid; n++) @(negedge clk);
        check(bus_valid === 1'b1, {req, " bus_valid"}, 64'(bus_valid), 64'd1);
        check(bus_addr === ea, {req, " bus_addr"}, 64'(bus_addr), 64'(ea));
        check(bus_mask === em, {req, " bus_mask"}, bus_mask, em);
        check(bus_full === ef, {req, " bus_full"}, 64'(bus_full), 64'(ef));
        check_wide({req, " bus_data"}, bus_data, ed);
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        check(flush_done === last, "R11 flush_done after accept", 64'(flush_done), 64'(last));
    endtask

    task automatic t_reset;
        check(bus_valid === 1'b0, "R1 bus_valid", 64'(bus_valid), 0);
        check(flush_done === 1'b0, "R1 flush_done", 64'(flush_done), 0);
        check(st_err === 1'b0, "R1 st_err", 64'(st_err), 0);
        check(st_ready === 1'b1, "R1 st_ready", 64'(st_ready), 1);
    endtask

    // R2, R3, R6: placement, merge and a partial line
    task automatic t_place_merge;
        logic [511:0] ed = '0;
        do_store(32'h2005, 64'h8877665544332211, 8'h0F);
        do_store(32'h2007, 64'h000000000000BBAA, 8'h03);
        ed[5*8 +: 8] = 8'h11; ed[6*8 +: 8] = 8'h22;
        ed[7*8 +: 8] = 8'hAA; ed[8*8 +: 8] = 8'hBB;
        pulse(3);
        check(bus_valid === 1'b1, "R7 fence drain starts", 64'(bus_valid), 1);
        take_line("R2 R3 R6 merged line", 32'h2000, 64'h1E0, 1'b0, ed, 1'b1);
    endtask

    // R4, R7, R8: two interleaved lines, bus held off
    task automatic t_two_lines;
        logic [511:0] ea = '0;
        logic [511:0] eb = '0;
        do_store(32'h4000, 64'hA1, 8'h01);
        do_store(32'h4040, 64'hB1, 8'h01);
        do_store(32'h4001, 64'hA2, 8'h01);
        do_store(32'h4041, 64'hB2, 8'h01);
        ea[7:0] = 8'hA1; ea[15:8] = 8'hA2;
        eb[7:0] = 8'hB1; eb[15:8] = 8'hB2;
        pulse(0);
        for (int n = 0; n < 3; n++) begin
            @(negedge clk);
            check(bus_valid === 1'b1 && bus_addr === 32'h4000, "R8 hold while not ready", 64'(bus_addr), 64'h4000);
            check(st_ready === 1'b0, "R8 st_ready low", 64'(st_ready), 0);
        end
        take_line("R4 line A", 32'h4000, 64'h3, 1'b0, ea, 1'b0);
        take_line("R4 line B", 32'h4040, 64'h3, 1'b0, eb, 1'b1);
    endtask

    // R5: full line
    task automatic t_full_line;
        logic [511:0] ed = '0;
        for (int c = 0; c < 8; c++) begin
            do_store(32'h3000 + 32'(c*8), {8{8'(8'h30 + c)}}, 8'hFF);
            ed[c*64 +: 64] = {8{8'(8'h30 + c)}};
        end
        pulse(1);
        take_line("R5 full line", 32'h3000, {64{1'b1}}, 1'b1, ed, 1'b1);
    endtask

    // R10: eviction of entry 0 and newest line drained first
    task automatic t_evict;
        logic [511:0] ed = '0;
        for (int i = 0; i < 4; i++) begin
            do_store(32'h5000 + 32'(i*64), 64'(8'h10 + i), 8'h01);
        end
        do_store(32'h5102, 64'h77, 8'h01);
        check(bus_valid === 1'b1 && bus_addr === 32'h5000, "R10 victim offered", 64'(bus_addr), 64'h5000);
        check(st_ready === 1'b0, "R10 st_ready low during evict", 64'(st_ready), 0);
        ed[7:0] = 8'h10;
        take_line("R10 victim", 32'h5000, 64'h1, 1'b0, ed, 1'b0);
        @(negedge clk);
        check(bus_valid === 1'b0, "R10 idle after evict", 64'(bus_valid), 0);
        pulse(2);
        ed = '0; ed[2*8 +: 8] = 8'h77;
        take_line("R10 newest first", 32'h5100, 64'h4, 1'b0, ed, 1'b0);
        for (int i = 1; i < 4; i++) begin
            ed = '0; ed[7:0] = 8'(8'h10 + i);
            take_line("R7 R10 older line", 32'h5000 + 32'(i*64), 64'h1, 1'b0, ed, i == 3);
        end
    endtask

    // R12, R11: refused store, empty drain
    task automatic t_cross;
        do_store(32'h603C, 64'h0123456789ABCDEF, 8'hFF);
        check(st_err === 1'b1, "R12 st_err pulse", 64'(st_err), 1);
        @(negedge clk);
        check(st_err === 1'b0, "R12 st_err one cycle", 64'(st_err), 0);
        pulse(3);
        check(flush_done === 1'b1, "R11 done on empty drain", 64'(flush_done), 1);
        check(bus_valid === 1'b0, "R12 refused store not buffered", 64'(bus_valid), 0);
    endtask

    // R9: idle timer
    task automatic t_idle;
        logic [511:0] ed = '0;
        idle_limit = 16'd5;
        do_store(32'h7000, 64'h5A, 8'h01);
        repeat (4) @(negedge clk);
        check(bus_valid === 1'b0, "R9 quiet before limit", 64'(bus_valid), 0);
        @(negedge clk);
        check(bus_valid === 1'b1, "R9 drain at limit", 64'(bus_valid), 1);
        ed[7:0] = 8'h5A;
        take_line("R9 idle drained line", 32'h7000, 64'h1, 1'b0, ed, 1'b1);
        idle_limit = 16'd0;
        do_store(32'h7040, 64'h5B, 8'h01);
        repeat (30) @(negedge clk);
        check(bus_valid === 1'b0, "R9 limit zero disables", 64'(bus_valid), 0);
        pulse(3);
        ed = '0; ed[7:0] = 8'h5B;
        take_line("R9 manual drain", 32'h7040, 64'h1, 1'b0, ed, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_place_merge();
        t_two_lines();
        t_full_line();
        t_evict();
        t_cross();
        t_idle();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule